// File: doc/BRIEF.md
# Interrupt Source Concentrator

This block collects 64 level-sensitive interrupt lines and funnels them into a single outstanding vector request. The low 32 lines come from PCI slots and the high 32 lines come from on-board peripherals. Each input level is registered every cycle. When nothing is pending, a fixed-priority picker chooses the lowest-numbered line that is both asserted and enabled. That line becomes the pending request. It is shown as one bit of a one-hot 64-bit vector and as a 7-bit source number.

Once a request is pending it stays put until software retires it. Software can retire it in two ways: by disabling the mapping register that gates it, or by writing the matching clear register. Enables sit in bit 31 of the mapping registers. Each PCI mapping register gates a group of four consecutive PCI lines, while each on-board line has a mapping register of its own. The low 31 bits of every mapping register are read-only routing constants.

Top module: `irq_concentrator`

## Requirements
- R1: Each input level is sampled into a latch register on every clock edge, so an input that rises while the block is idle and enabled shows as a request two clock edges later.
- R2: A mapping register reads as {enable, constant}. For PCI register k the constant is (0x1F<<6)|(k<<2). For on-board register j it is 0x7E0+j. A write changes only bit 31; bits 30:0 never change.
- R3: PCI source i (0..31) is gated by the enable of PCI mapping register i/4, which is shared by the four lines of the group. On-board source 32+j is gated by on-board mapping register j.
- R4: When idle, the lowest-numbered latched and enabled source wins. Every PCI source (0..31) therefore beats every on-board source (32..63).
- R5: A pending request keeps its vec_req bit and req_id unchanged until it is cleared. A lower-numbered source that arrives in the meantime, or the pending source's own input dropping, has no effect.
- R6: A mapping-register write with bit 31 = 0 to the register that gates the pending source drops the request on that edge, and a new winner is selected on the following edge. A write with bit 31 = 1, or a write to any other register, leaves the request pending.
- R7: A write to PCI clear register k clears the request when the pending source is below 32 and source/4 equals k. A write to on-board clear register j clears it only when the pending source equals 32+j. Any other clear write has no effect.
- R8: Reset clears every enable and the input latch, and sets the pending number to "none", shown as req_id = 65 with vec_req all zero.
- R9: Mapping and clear registers respond only when address bit 2 is 1. A write with bit 2 = 0 is ignored, and a read with bit 2 = 0 returns 0.
- R10: The 10-bit byte address map is as follows. PCI mapping register k is at 0x000+8k+4 (k < 8). On-board mapping register j is at 0x100+8j+4. PCI clear register k is at 0x200+8k+4. On-board clear register j is at 0x300+8j+4. Clear registers and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines: 0..31 PCI, 32..63 on-board |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 10 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| vec_req | output | 64 | One-hot pending vector request |
| req_id | output | 7 | Pending source number, 65 when none |

## Verification
Several lines are raised together, so a picker that scans from the top, or that orders on-board lines ahead of PCI lines, names the wrong winner. A lower line is raised and the winner's own line is dropped while a request is pending; a design that re-arbitrates every cycle would switch requests or drop them. Clear writes are aimed at near-miss indices, such as a PCI clear of the wrong group or an on-board clear one off, and a mapping write that keeps the enable set. A decoder that is too loose would retire the request early. A shared-enable test leaves a disabled group with a line asserted, and then enables that group. A per-line gating mistake would either fire too soon or never fire. Writes with address bit 2 clear are checked to leave the enables alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BUS_AW = 10;
    localparam int BUS_DW = 32;
    localparam int EN_BIT = 31;
    localparam int ID_W   = 7;
    localparam logic [ID_W-1:0] ID_NONE = 7'd65;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PCI_MAP,
        SEL_OB_MAP,
        SEL_PCI_CLR,
        SEL_OB_CLR
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [4:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic       valid;
        sel_kind_e  kind;
        logic [4:0] idx;
        logic       en;
    } wr_evt_t;

    // Register selection; bit 2 qualifies every register.
    function automatic reg_sel_t decode_addr(input logic [BUS_AW-1:0] a);
        reg_sel_t s;
        s.kind = SEL_NONE;
        s.idx  = a[7:3];
        if (a[2]) begin
            case (a[9:8])
                2'd0: if (a[7:6] == 2'b00) s.kind = SEL_PCI_MAP;
                2'd1: s.kind = SEL_OB_MAP;
                2'd2: if (a[7:6] == 2'b00) s.kind = SEL_PCI_CLR;
                default: s.kind = SEL_OB_CLR;
            endcase
        end
        return s;
    endfunction

    function automatic logic [30:0] pci_map_low(input int k);
        return 31'((32'h1F << 6) | (k << 2));
    endfunction

    function automatic logic [30:0] ob_map_low(input int j);
        return 31'(32'h7E0 + j);
    endfunction
endpackage

// File: rtl/irqc_map_regs.sv
module irqc_map_regs
    import irqc_pkg::*;
#(
    parameter int NUM_PMAP = 8,
    parameter int NUM_OB   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              wr_en_bit,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [NUM_PMAP-1:0] pci_en,
    output logic [NUM_OB-1:0]   ob_en,
    output wr_evt_t           wr_evt
);
    reg_sel_t sel;
    assign sel = decode_addr(bus_addr);

    assign wr_evt.valid = bus_wr;
    assign wr_evt.kind  = sel.kind;
    assign wr_evt.idx   = sel.idx;
    assign wr_evt.en    = wr_en_bit;

    for (genvar g = 0; g < NUM_PMAP; g++) begin : g_pci
        always_ff @(posedge clk) begin
            if (rst)
                pci_en[g] <= 1'b0;
            else if (bus_wr && sel.kind == SEL_PCI_MAP && sel.idx == 5'(g))
                pci_en[g] <= wr_en_bit;
        end

        p_pci_en_write_r2: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && sel.kind == SEL_PCI_MAP && sel.idx == 5'(g))
            |=> pci_en[g] == $past(wr_en_bit));
    end

    for (genvar g = 0; g < NUM_OB; g++) begin : g_ob
        always_ff @(posedge clk) begin
            if (rst)
                ob_en[g] <= 1'b0;
            else if (bus_wr && sel.kind == SEL_OB_MAP && sel.idx == 5'(g))
                ob_en[g] <= wr_en_bit;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            SEL_PCI_MAP:
                for (int k = 0; k < NUM_PMAP; k++)
                    if (sel.idx == 5'(k)) bus_rdata = {pci_en[k], pci_map_low(k)};
            SEL_OB_MAP:
                for (int j = 0; j < NUM_OB; j++)
                    if (sel.idx == 5'(j)) bus_rdata = {ob_en[j], ob_map_low(j)};
            default: bus_rdata = '0;
        endcase
    end

    p_bit2_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[2]) |=> ($stable(pci_en) && $stable(ob_en)));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int NUM_PCI     = 32,
    parameter int PCI_PER_MAP = 4,
    parameter int NUM_OB      = 32,
    localparam int NUM_SRC    = NUM_PCI + NUM_OB,
    localparam int NUM_PMAP   = NUM_PCI / PCI_PER_MAP,
    localparam int SRC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] lat,
    input  logic [NUM_PMAP-1:0] pci_en,
    input  logic [NUM_OB-1:0]  ob_en,
    output logic               win_valid,
    output logic [SRC_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] eligible;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        if (i < NUM_PCI) begin : g_pci
            assign eligible[i] = lat[i] & pci_en[i / PCI_PER_MAP];
        end else begin : g_ob
            assign eligible[i] = lat[i] & ob_en[i - NUM_PCI];
        end
    end

    // Lowest index wins; PCI lines occupy the low indices.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                win_valid = 1'b1;
                win_idx   = SRC_W'(i);
            end
        end
    end

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (eligible[win_idx] &&
                       ((eligible & ((NUM_SRC'(1) << win_idx) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irqc_hold.sv
module irqc_hold
    import irqc_pkg::*;
#(
    parameter int NUM_PCI     = 32,
    parameter int PCI_PER_MAP = 4,
    parameter int NUM_OB      = 32,
    localparam int NUM_SRC    = NUM_PCI + NUM_OB,
    localparam int SRC_W      = $clog2(NUM_SRC),
    localparam int GRP_SHIFT  = $clog2(PCI_PER_MAP)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  wr_evt_t            wr_evt,
    input  logic               win_valid,
    input  logic [SRC_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] lat,
    output logic               pend_valid,
    output logic [SRC_W-1:0]   pend_idx
);
    logic             pend_is_pci;
    logic [SRC_W-1:0] pci_grp;
    logic [SRC_W-1:0] ob_num;
    logic [SRC_W-1:0] evt_idx;
    logic             hit;
    logic             clear_hit;

    assign pend_is_pci = pend_idx < SRC_W'(NUM_PCI);
    assign pci_grp     = pend_idx >> GRP_SHIFT;
    assign ob_num      = pend_idx - SRC_W'(NUM_PCI);
    assign evt_idx     = SRC_W'(wr_evt.idx);

    always_comb begin
        case (wr_evt.kind)
            SEL_PCI_MAP: hit = !wr_evt.en && pend_is_pci && (pci_grp == evt_idx);
            SEL_OB_MAP:  hit = !wr_evt.en && !pend_is_pci && (ob_num == evt_idx);
            SEL_PCI_CLR: hit = pend_is_pci && (pci_grp == evt_idx);
            SEL_OB_CLR:  hit = !pend_is_pci && (ob_num == evt_idx);
            default:     hit = 1'b0;
        endcase
    end

    assign clear_hit = wr_evt.valid && pend_valid && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat        <= '0;
            pend_valid <= 1'b0;
            pend_idx   <= '0;
        end else begin
            lat <= irq_in;
            if (clear_hit) begin
                pend_valid <= 1'b0;
            end else if (!pend_valid && win_valid) begin
                pend_valid <= 1'b1;
                pend_idx   <= win_idx;
            end
        end
    end

    p_latch_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> lat == $past(irq_in));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !clear_hit) |=> (pend_valid && pend_idx == $past(pend_idx)));

    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        clear_hit |=> !pend_valid);

    p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pend_valid && lat == '0));
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
    import irqc_pkg::*;
#(
    parameter int NUM_PCI     = 32,
    parameter int PCI_PER_MAP = 4,
    parameter int NUM_OB      = 32,
    localparam int NUM_SRC    = NUM_PCI + NUM_OB,
    localparam int NUM_PMAP   = NUM_PCI / PCI_PER_MAP,
    localparam int SRC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic [NUM_SRC-1:0] vec_req,
    output logic [ID_W-1:0]    req_id
);
    logic [NUM_PMAP-1:0] pci_en;
    logic [NUM_OB-1:0]   ob_en;
    wr_evt_t             wr_evt;
    logic [NUM_SRC-1:0]  lat;
    logic                win_valid;
    logic [SRC_W-1:0]    win_idx;
    logic                pend_valid;
    logic [SRC_W-1:0]    pend_idx;

    irqc_map_regs #(.NUM_PMAP(NUM_PMAP), .NUM_OB(NUM_OB)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .bus_rdata (bus_rdata),
        .pci_en    (pci_en),
        .ob_en     (ob_en),
        .wr_evt    (wr_evt)
    );

    irqc_pick #(.NUM_PCI(NUM_PCI), .PCI_PER_MAP(PCI_PER_MAP), .NUM_OB(NUM_OB)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .lat       (lat),
        .pci_en    (pci_en),
        .ob_en     (ob_en),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    irqc_hold #(.NUM_PCI(NUM_PCI), .PCI_PER_MAP(PCI_PER_MAP), .NUM_OB(NUM_OB)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .wr_evt     (wr_evt),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .lat        (lat),
        .pend_valid (pend_valid),
        .pend_idx   (pend_idx)
    );

    assign vec_req = pend_valid ? (NUM_SRC'(1) << pend_idx) : '0;
    assign req_id  = pend_valid ? ID_W'(pend_idx) : ID_NONE;

    // Only a register write may retire or replace a visible request.
    p_out_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (vec_req != '0 && !bus_wr) |=> $stable(vec_req));
endmodule

// File: tb/irq_concentrator_test.sv
`timescale 1ns/1ps
module irq_concentrator_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] irq_in;
    logic        bus_wr;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] vec_req;
    logic [6:0]  req_id;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_concentrator uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vec_req(vec_req), .req_id(req_id)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_req(input int id, input string tag);
        check({tag, " req_id"}, 64'(req_id), 64'(id));
        check({tag, " vec_req"}, vec_req, (id == 65) ? 64'd0 : (64'd1 << id));
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [9:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; irq_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_n(3);
        rst = 1'b0;
        expect_req(65, "R8 idle after reset");
        rd_check(10'h01C, 32'h0000_07CC, "R2 R8 PCI map 3 reset value");
        rd_check(10'h12C, 32'h0000_07E5, "R2 R8 on-board map 5 reset value");
        irq_in = 64'd1;
        wait_n(3);
        expect_req(65, "R8 enables cleared by reset");
        irq_in = '0;
    endtask

    task automatic t_enable_all;
        for (int k = 0; k < 8; k++) wr(10'(8 * k + 4), 32'hFFFF_FFFF);
        for (int j = 0; j < 32; j++) wr(10'(10'h100 + 8 * j + 4), 32'hFFFF_FFFF);
        rd_check(10'h01C, 32'h8000_07CC, "R2 R10 PCI map 3 low bits unchanged");
        rd_check(10'h1FC, 32'h8000_07FF, "R2 R10 on-board map 31");
        rd_check(10'h204, 32'h0, "R10 clear register reads 0");
    endtask

    task automatic t_bit2;
        wr(10'h018, 32'h0);
        rd_check(10'h01C, 32'h8000_07CC, "R9 write without bit 2 ignored");
        rd_check(10'h018, 32'h0, "R9 read without bit 2 is 0");
    endtask

    task automatic t_priority_hold;
        @(negedge clk);
        irq_in = (64'd1 << 40) | (64'd1 << 5) | (64'd1 << 3);
        wait_n(2);
        expect_req(3, "R1 R4 lowest wins after two edges");
        irq_in = (64'd1 << 40) | (64'd1 << 5) | (64'd1 << 1);
        wait_n(3);
        expect_req(3, "R5 held despite lower line and own line drop");
        wr(10'h20C, 32'h0);
        expect_req(3, "R7 PCI clear of wrong group no effect");
        wr(10'h204, 32'h0);
        expect_req(65, "R7 PCI clear of group 0");
        wait_n(1);
        expect_req(1, "R4 re-selection picks lowest");
    endtask

    task automatic t_map_clear;
        wr(10'h004, 32'h0);
        expect_req(65, "R6 disabling map drops pending");
        wait_n(1);
        expect_req(5, "R3 R4 group 0 gated, PCI 5 beats on-board 40");
        irq_in = (64'd1 << 40) | (64'd1 << 1);
        wr(10'h20C, 32'h0);
        expect_req(65, "R7 PCI clear group 1");
        wait_n(1);
        expect_req(40, "R4 on-board source selected");
    endtask

    task automatic t_ob_clear;
        wr(10'h33C, 32'h0);
        expect_req(40, "R7 on-board clear off by one no effect");
        wr(10'h144, 32'h8000_0000);
        expect_req(40, "R6 map write keeping enable no effect");
        rd_check(10'h144, 32'h8000_07E8, "R2 on-board map 8 readback");
        irq_in = 64'd1 << 1;
        wr(10'h344, 32'h0);
        expect_req(65, "R7 on-board clear exact match");
        wait_n(2);
        expect_req(65, "R3 line 1 still gated");
    endtask

    task automatic t_shared_enable;
        irq_in = 64'd1 << 2;
        wait_n(3);
        expect_req(65, "R3 shared group disabled");
        wr(10'h004, 32'h8000_0000);
        expect_req(65, "R3 enable takes effect after write");
        wait_n(1);
        expect_req(2, "R3 shared enable fires line 2");
        irq_in = 64'd1 << 63;
        wr(10'h204, 32'h0);
        expect_req(65, "R7 clear line 2");
        wait_n(1);
        expect_req(63, "R4 on-board 63 selected");
        wr(10'h1FC, 32'h0);
        expect_req(65, "R6 on-board map disable drops");
        wait_n(2);
        expect_req(65, "R3 on-board 63 gated");
    endtask

    task automatic t_reset_mid;
        wr(10'h1FC, 32'h8000_0000);
        wait_n(1);
        expect_req(63, "R3 on-board 63 re-enabled");
        @(negedge clk);
        rst = 1'b1; irq_in = '0;
        @(negedge clk);
        rst = 1'b0;
        expect_req(65, "R8 reset drops pending");
        rd_check(10'h004, 32'h0000_07C0, "R8 PCI map 0 enable cleared");
        rd_check(10'h1FC, 32'h0000_07FF, "R8 on-board map 31 enable cleared");
    endtask

    initial begin
        t_reset;
        t_enable_all;
        t_bit2;
        t_priority_hold;
        t_map_clear;
        t_ob_clear;
        t_shared_enable;
        t_reset_mid;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule